// File: doc/BRIEF.md
# Sleep and Refresh-Mode Sequencer for a Self-Refreshing SRAM-Compatible Memory

This block is the power-state sequencer for a DRAM-based memory that looks like an asynchronous SRAM from outside and refreshes itself without help. It runs on a free-running clock and is given a one-cycle pulse once per microsecond. From the active-low chip select, sleep, write and byte-select strobes it tracks where the memory is in its power life. The states are the power-up settle, the initial and idle states, normal access, and the two sleep states. One sleep state keeps a chosen part of the array refreshed. The other switches refresh off and loses the array contents.

An 8-bit setup register is written from the low address byte. This happens when chip select, sleep and write are all asserted in a normal state. Bit 4 of this register decides which sleep state a sleep request enters. A deep sleep must dwell long enough before it takes effect, and waking from it costs a recovery period. After that period the setup register falls back to its default value. Every wait is counted in microsecond ticks. The block reports the current mode, a ready flag, the setup value, a flag telling whether the array contents are still held, and a sticky flag for a setup write that came in the wrong state.

Top module: `psram_standby_ctrl`

## Requirements
- R1: In reset and just after it, mode is 0 (power-up), ready is 0, cfg is 8'h70, data_valid is 1 and proto_err is 0. In 8'h70, bits 6:5 = 11, bit 4 = 1 (deep sleep off), bit 3 = 0, bit 2 = 0, bits 1:0 = 00 and bit 7 = 0.
- R2: Mode leaves 0 only after PWRUP_US ticks counted while ce_n is high. Any cycle with ce_n low restarts that count. The exit goes to mode 1 (initial).
- R3: ready is 1 exactly in modes 1 (initial), 2 (standby) and 3 (active). It is 0 in the sleep, deep-sleep, recovery and power-up modes.
- R4: In modes 1 to 3, a clock edge that sees ce_n, sleep_n and we_n all low loads addr_lo into cfg. The new value is visible after that edge.
- R5: In modes 1 to 3, sleep_n high with ce_n low and at least one of lb_n and ub_n low gives mode 3. sleep_n high with ce_n high gives mode 2. ce_n low with both byte selects high leaves the mode as it is.
- R6: With cfg bit 4 = 1, sleep_n low with ce_n high in modes 1 to 3 enters mode 4 (partial refresh). sleep_n high in mode 4 returns to mode 2, and cfg and data_valid keep their values.
- R7: With cfg bit 4 = 0, the same request enters mode 5 (deep-sleep dwell). If sleep_n rises before DPD_MIN_US ticks, the block returns to mode 2 and keeps both cfg and data_valid.
- R8: After DPD_MIN_US ticks in mode 5, the block enters mode 6 (deep sleep) and data_valid drops to 0.
- R9: sleep_n high in mode 6 gives mode 7 (recovery), with ready 0 and data_valid 0. After RECOVER_US ticks the block passes through mode 1 with cfg = 8'h70 and data_valid = 1.
- R10: A setup write attempt (ce_n, sleep_n and we_n all low) in any mode other than 1 to 3 leaves cfg unchanged. It sets proto_err, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| ce_n | input | 1 | Chip select, active low |
| sleep_n | input | 1 | Sleep request, active low |
| we_n | input | 1 | Write strobe, active low |
| lb_n | input | 1 | Low byte select, active low |
| ub_n | input | 1 | High byte select, active low |
| addr_lo | input | CFG_W | Low address byte, source of setup writes |
| mode | output | 3 | Current power mode, codes 0 to 7 |
| ready | output | 1 | Memory may be accessed |
| cfg | output | CFG_W | Setup register value |
| data_valid | output | 1 | Array contents are still held |
| proto_err | output | 1 | Sticky flag for a misplaced setup write |

## Verification
A wrong state in this sequencer shows on the mode and ready outputs one clock after the strobe that caused it. The exception is the timed exits, which show only once the tick count reaches its limit. For those, the bench samples well before and after each limit, so an early or late exit is caught within a few ticks. A lost or stray setup write shows on cfg at the next edge. A wrong wake-up restore only becomes visible after the full recovery wait, when cfg should read 8'h70 again.

// File: rtl/psram_standby_pkg.sv
package psram_standby_pkg;

  localparam int CFG_W = 8;
  localparam int CFG_DEEP_OFF_BIT = 4;

  typedef enum logic [2:0] {
    M_PWRON     = 3'd0,
    M_INIT      = 3'd1,
    M_STANDBY   = 3'd2,
    M_ACTIVE    = 3'd3,
    M_PAR       = 3'd4,
    M_DPD_ENTRY = 3'd5,
    M_DPD       = 3'd6,
    M_RECOVER   = 3'd7
  } pmode_e;

  // Setup value after power-up or deep-sleep wake.
  function automatic logic [CFG_W-1:0] cfg_default();
    logic [CFG_W-1:0] v;
    v = '0;
    v[6:5] = 2'b11;            // temperature range: hottest
    v[CFG_DEEP_OFF_BIT] = 1'b1; // deep sleep disabled
    return v;
  endfunction

  function automatic logic mode_is_ready(pmode_e m);
    return (m == M_INIT) || (m == M_STANDBY) || (m == M_ACTIVE);
  endfunction

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (count_en && !done)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg
  import psram_standby_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CFG_W-1:0] load_val,
  input  logic             restore,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= cfg_default();
    else if (restore)
      cfg_q <= cfg_default();
    else if (load_en)
      cfg_q <= load_val;
  end

endmodule

// File: rtl/psram_standby_ctrl.sv
module psram_standby_ctrl
  import psram_standby_pkg::*;
#(
  parameter int PWRUP_US   = 200,
  parameter int DPD_MIN_US = 10,
  parameter int RECOVER_US = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             ce_n,
  input  logic             sleep_n,
  input  logic             we_n,
  input  logic             lb_n,
  input  logic             ub_n,
  input  logic [CFG_W-1:0] addr_lo,
  output logic [2:0]       mode,
  output logic             ready,
  output logic [CFG_W-1:0] cfg,
  output logic             data_valid,
  output logic             proto_err
);

  localparam int MAX_WAIT = (PWRUP_US > RECOVER_US)
                            ? ((PWRUP_US > DPD_MIN_US) ? PWRUP_US : DPD_MIN_US)
                            : ((RECOVER_US > DPD_MIN_US) ? RECOVER_US : DPD_MIN_US);
  localparam int CW = $clog2(MAX_WAIT + 1);

  pmode_e state_q, state_d;

  // Named events, also used by the checker
  logic ready_st, load_attempt, load_fire, load_reject;
  logic sleep_req, wake_active, idle_req;
  logic timer_done, timer_clear, timer_en;
  logic restore_cfg;
  logic [CW-1:0] wait_lim;

  assign ready_st     = mode_is_ready(state_q);
  assign load_attempt = !ce_n && !sleep_n && !we_n;
  assign load_fire    = load_attempt && ready_st;
  assign load_reject  = load_attempt && !ready_st;
  assign sleep_req    = !sleep_n && ce_n;
  assign wake_active  = sleep_n && !ce_n && (!lb_n || !ub_n);
  assign idle_req     = sleep_n && ce_n;

  function automatic logic [CW-1:0] limit_for(pmode_e s);
    case (s)
      M_PWRON:     return CW'(PWRUP_US);
      M_DPD_ENTRY: return CW'(DPD_MIN_US);
      M_RECOVER:   return CW'(RECOVER_US);
      default:     return '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      M_PWRON:     if (timer_done) state_d = M_INIT;
      M_INIT, M_STANDBY, M_ACTIVE: begin
        if (sleep_req)
          state_d = cfg[CFG_DEEP_OFF_BIT] ? M_PAR : M_DPD_ENTRY;
        else if (wake_active)
          state_d = M_ACTIVE;
        else if (idle_req)
          state_d = M_STANDBY;
      end
      M_PAR:       if (sleep_n) state_d = M_STANDBY;
      M_DPD_ENTRY: begin
        if (sleep_n)         state_d = M_STANDBY;
        else if (timer_done) state_d = M_DPD;
      end
      M_DPD:       if (sleep_n) state_d = M_RECOVER;
      M_RECOVER:   if (timer_done) state_d = M_INIT;
      default:     state_d = M_PWRON;
    endcase
  end

  assign wait_lim    = limit_for(state_q);
  assign timer_clear = (state_d != state_q) || ((state_q == M_PWRON) && !ce_n);
  assign timer_en    = us_tick && (((state_q == M_PWRON) && ce_n) ||
                                   (state_q == M_DPD_ENTRY) ||
                                   (state_q == M_RECOVER));
  assign restore_cfg = (state_q == M_RECOVER) && timer_done;

  psram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .count_en (timer_en),
    .limit    (wait_lim),
    .done     (timer_done)
  );

  psram_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_fire),
    .load_val (addr_lo),
    .restore  (restore_cfg),
    .cfg_q    (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= M_PWRON;
      proto_err <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_reject) proto_err <= 1'b1;
    end
  end

  assign mode       = state_q;
  assign ready      = ready_st;
  assign data_valid = !((state_q == M_DPD) || (state_q == M_RECOVER));

endmodule

// File: rtl/psram_standby_chk.sv
module psram_standby_chk
  import psram_standby_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             sleep_n,
  input logic [2:0]       mode,
  input logic [CFG_W-1:0] cfg,
  input logic             data_valid,
  input logic             proto_err,
  input logic             load_fire,
  input logic             timer_done
);

  // R2
  pwron_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_PWRON && mode != M_PWRON) |-> (mode == M_INIT && $past(timer_done)));

  // R4
  cfg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> ($past(load_fire) || $past(mode) == M_RECOVER));

  // R6
  par_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == M_PAR && sleep_n) |-> (mode == M_STANDBY && $stable(cfg)));

  // R7
  dpd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPD_ENTRY && $past(mode) != M_DPD_ENTRY)
      |-> ($past(cfg[CFG_DEEP_OFF_BIT]) == 1'b0 && !$past(sleep_n) && $past(ce_n)));

  // R8
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> (mode == M_DPD && $past(mode) == M_DPD_ENTRY));

  // R9
  recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_RECOVER && mode != M_RECOVER) |-> (mode == M_INIT && cfg == cfg_default()));

  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);

endmodule

bind psram_standby_ctrl psram_standby_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .sleep_n    (sleep_n),
  .mode       (mode),
  .cfg        (cfg),
  .data_valid (data_valid),
  .proto_err  (proto_err),
  .load_fire  (load_fire),
  .timer_done (timer_done)
);

// File: tb/psram_standby_ctrl_bench.sv
`timescale 1ns/1ps
module psram_standby_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic ce_n = 1'b1, sleep_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [7:0] addr_lo = 8'h00;
  logic [2:0] mode;
  logic ready, data_valid, proto_err;
  logic [7:0] cfg;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  // one tick every second clock
  always @(negedge clk) us_tick <= ~us_tick;
  always @(posedge clk) if (us_tick) tick_cnt <= tick_cnt + 1;

  psram_standby_ctrl u_psram_standby_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ce_n(ce_n), .sleep_n(sleep_n),
    .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr_lo(addr_lo), .mode(mode),
    .ready(ready), .cfg(cfg), .data_valid(data_valid), .proto_err(proto_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(int n);
    int start;
    start = tick_cnt;
    while (tick_cnt - start < n) @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1 mode", mode, 3'd0);
    chk("R1 ready", ready, 1'b0);
    chk("R1 cfg", cfg, 8'h70);
    chk("R1 data_valid", data_valid, 1'b1);
    chk("R1 proto_err", proto_err, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 mode after release", mode, 3'd0);
  endtask

  task automatic t_powerup();
    wait_ticks(150);
    chk("R2 still power-up at 150", mode, 3'd0);
    ce_n = 1'b0;
    repeat (3) step();
    ce_n = 1'b1;
    wait_ticks(150);
    chk("R2 count restarted", mode, 3'd0);
    chk("R3 ready low in power-up", ready, 1'b0);
    wait_ticks(55);
    repeat (2) step();
    chk("R2 left power-up to standby", mode, 3'd2);
    chk("R3 ready in standby", ready, 1'b1);
  endtask

  task automatic t_access();
    ce_n = 1'b0; lb_n = 1'b0;
    step();
    chk("R5 active on low byte", mode, 3'd3);
    chk("R3 ready in active", ready, 1'b1);
    lb_n = 1'b1; ub_n = 1'b0;
    step();
    chk("R5 active on high byte", mode, 3'd3);
    ub_n = 1'b1; ce_n = 1'b1;
    step();
    chk("R5 back to standby", mode, 3'd2);
    ce_n = 1'b0;
    repeat (2) step();
    chk("R5 no byte select keeps standby", mode, 3'd2);
    ce_n = 1'b1;
    step();
  endtask

  task automatic t_load(logic [7:0] v);
    ce_n = 1'b0; sleep_n = 1'b0; we_n = 1'b0; addr_lo = v;
    step();
    ce_n = 1'b1; sleep_n = 1'b1; we_n = 1'b1; addr_lo = 8'h00;
    step();
    chk("R4 cfg loaded", cfg, v);
    chk("R4 mode after load", mode, 3'd2);
  endtask

  task automatic t_partial();
    sleep_n = 1'b0;
    step();
    chk("R6 partial refresh entered", mode, 3'd4);
    chk("R3 ready low in partial", ready, 1'b0);
    ce_n = 1'b0; we_n = 1'b0; addr_lo = 8'hAB;
    step();
    ce_n = 1'b1; we_n = 1'b1; addr_lo = 8'h00;
    step();
    chk("R10 cfg unchanged by misplaced write", cfg, 8'h1D);
    chk("R10 proto_err set", proto_err, 1'b1);
    chk("R6 stays partial", mode, 3'd4);
    sleep_n = 1'b1;
    step();
    chk("R6 exit to standby", mode, 3'd2);
    chk("R6 cfg kept", cfg, 8'h1D);
    chk("R6 data kept", data_valid, 1'b1);
  endtask

  task automatic t_dpd_abort();
    sleep_n = 1'b0;
    step();
    chk("R7 dwell entered", mode, 3'd5);
    wait_ticks(5);
    chk("R7 still dwelling", mode, 3'd5);
    chk("R7 data held in dwell", data_valid, 1'b1);
    sleep_n = 1'b1;
    step();
    chk("R7 short dwell back to standby", mode, 3'd2);
    chk("R7 cfg kept", cfg, 8'h0C);
    chk("R7 data kept", data_valid, 1'b1);
  endtask

  task automatic t_dpd_full();
    sleep_n = 1'b0;
    step();
    wait_ticks(12);
    chk("R8 deep sleep reached", mode, 3'd6);
    chk("R8 data invalid", data_valid, 1'b0);
    wait_ticks(20);
    chk("R8 deep sleep holds", mode, 3'd6);
    sleep_n = 1'b1;
    step();
    chk("R9 recovery entered", mode, 3'd7);
    chk("R9 ready low in recovery", ready, 1'b0);
    wait_ticks(100);
    chk("R9 still recovering", mode, 3'd7);
    chk("R9 data invalid in recovery", data_valid, 1'b0);
    wait_ticks(105);
    repeat (2) step();
    chk("R9 back to standby", mode, 3'd2);
    chk("R9 cfg default restored", cfg, 8'h70);
    chk("R9 data valid again", data_valid, 1'b1);
    chk("R10 proto_err sticky", proto_err, 1'b1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_access();
    t_load(8'h1D);
    t_partial();
    t_load(8'h0C);
    t_dpd_abort();
    t_dpd_full();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule